// File: doc/BRIEF.md
# Sink Capability Reader and Validator

This block fetches the opening capability bytes of an attached display sink and decides whether the link can be brought up with them. A one-cycle start request launches a burst read through an abstract register-read port. The block names the start offset and the byte count and then collects the returned bytes one per cycle. A burst that the responder flags as failed, or that returns the wrong number of bytes, is reissued, up to a bounded number of attempts.

Once a clean burst has been captured, three fields are checked. Byte 0 holds the revision, byte 1 the maximum link-rate code and byte 2 the maximum lane count. How byte 2 is decoded depends on the revision, and the enhanced-framing capability comes from the same byte. After the checks pass, the block either finishes at once, when identification data is already held locally, or asks a downstream fetch engine to read that data and waits for its verdict. The result is a pass flag, a reason code, and the accepted revision, rate code, lane count and enhanced-framing flag. These are presented together with a one-cycle done pulse and stay stable until the next start.

Top module: `sink_cap_reader`

## Requirements
- R1: After reset, busyOut, doneOut, passOut, burstReq and edidReq are 0, reasonCode is 0, and capRev, capRate, capLanes and capEnhFrame are 0.
- R2: A startReq pulse while idle raises burstReq for exactly one cycle, with burstAddr = 0x00 and burstLen = 12. Returned bytes arrive on rspValid/rspData, byte k of the burst being the k-th valid beat. The burst ends with a one-cycle rspDone that carries no byte.
- R3: A burst counts as failed when rspFail is high with rspDone, or when the number of bytes is not exactly 12. A failed burst is reissued, at most 5 attempts in total. If the 5th attempt also fails, the block finishes with passOut = 0 and reasonCode = 1 and makes no EDID request.
- R4: Byte 0 must be 0x10 or 0x11. Any other value gives passOut = 0 and reasonCode = 2.
- R5: Byte 1 must be 0x06 or 0x0A. Any other value gives passOut = 0 and reasonCode = 3.
- R6: When byte 0 is 0x11, the lane count is bits 4:0 of byte 2 and capEnhFrame is bit 7 of byte 2. When byte 0 is 0x10, the lane count is all 8 bits of byte 2 and capEnhFrame is 0.
- R7: The decoded lane count must be 1, 2 or 4. Any other value gives passOut = 0 and reasonCode = 4.
- R8: The fields are checked in the order revision, rate, lane count, and the first one that fails sets reasonCode.
- R9: If all fields are valid and edidPreloaded is 1, the block passes without raising edidReq. Otherwise it raises edidReq for one cycle and waits for edidDone. edidOk = 1 then gives a pass, and edidOk = 0 gives reasonCode = 5.
- R10: doneOut is a one-cycle pulse, with busyOut low in that cycle. All result outputs hold their values until the next accepted start. A startReq while busy is ignored.
- R11: On a pass, reasonCode is 0 and the cap outputs carry the accepted fields. On any failure, capRev, capRate, capLanes and capEnhFrame are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a capability read |
| edidPreloaded | input | 1 | Identification data already held; skip fetch |
| burstReq | output | 1 | One-cycle burst read request |
| burstAddr | output | 8 | Burst start offset (0x00) |
| burstLen | output | 8 | Burst byte count |
| rspValid | input | 1 | Returned byte valid |
| rspData | input | 8 | Returned byte |
| rspDone | input | 1 | Burst finished |
| rspFail | input | 1 | Burst failed (with rspDone) |
| edidReq | output | 1 | One-cycle request to fetch identification data |
| edidDone | input | 1 | Fetch finished |
| edidOk | input | 1 | Fetch result good (with edidDone) |
| busyOut | output | 1 | Operation in progress |
| doneOut | output | 1 | Result valid pulse |
| passOut | output | 1 | Result: capabilities accepted |
| reasonCode | output | 3 | 0 none, 1 read, 2 revision, 3 rate, 4 lanes, 5 fetch |
| capRev | output | 8 | Accepted revision byte |
| capRate | output | 8 | Accepted link-rate code |
| capLanes | output | 5 | Accepted lane count |
| capEnhFrame | output | 1 | Enhanced framing supported |

## Verification
The bench builds the block with its default parameters: a 12-byte burst and 5 attempts. That makes it possible to run out of attempts and to succeed on the very last one within a few hundred cycles. A short 11-byte burst brings the byte-count failure path within reach without the fail flag. The 12-byte length also lets the bench fill bytes 3 to 11 with values that must play no part in the decision. Both revisions are driven against lane bytes whose upper bits differ, so the revision-dependent decode, the enhanced-framing extraction and the field-order priority are each observed at the ports.

// File: rtl/sink_cap_pkg.sv
package sink_cap_pkg;

  localparam logic [7:0] REV_V10  = 8'h10;
  localparam logic [7:0] REV_V11  = 8'h11;
  localparam logic [7:0] RATE_LOW = 8'h06;
  localparam logic [7:0] RATE_HIGH = 8'h0A;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_READ  = 3'd1,
    RSN_REV   = 3'd2,
    RSN_RATE  = 3'd3,
    RSN_LANES = 3'd4,
    RSN_EDID  = 3'd5
  } reason_t;

  // control -> datapath
  typedef struct packed {
    logic    clearBuf;
    logic    collect;
    logic    commit;
    reason_t verdict;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic countOk;
    logic revBad;
    logic rateBad;
    logic laneBad;
  } flags_t;

endpackage

// File: rtl/sink_cap_ctrl.sv
module sink_cap_ctrl
  import sink_cap_pkg::*;
#(
  parameter int MAX_TRIES = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    edidPreloaded,
  input  logic    rspDone,
  input  logic    rspFail,
  input  logic    edidDone,
  input  logic    edidOk,
  input  flags_t  flags,
  output strobe_t strobes,
  output logic    burstReq,
  output logic    edidReq,
  output logic    busy
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_CHECK, ST_EREQ, ST_EWAIT, ST_FINISH
  } state_t;

  state_t state;
  logic [TRY_W-1:0] tryCnt;
  reason_t verdictQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tryCnt   <= '0;
      verdictQ <= RSN_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            tryCnt   <= '0;
            verdictQ <= RSN_NONE;
            state    <= ST_REQ;
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (rspDone) begin
            if (rspFail || !flags.countOk) begin
              if (tryCnt == LAST_TRY) begin
                verdictQ <= RSN_READ;
                state    <= ST_FINISH;
              end else begin
                tryCnt <= tryCnt + 1'b1;
                state  <= ST_REQ;
              end
            end else begin
              state <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (flags.revBad) begin
            verdictQ <= RSN_REV;
            state    <= ST_FINISH;
          end else if (flags.rateBad) begin
            verdictQ <= RSN_RATE;
            state    <= ST_FINISH;
          end else if (flags.laneBad) begin
            verdictQ <= RSN_LANES;
            state    <= ST_FINISH;
          end else if (edidPreloaded) begin
            state <= ST_FINISH;
          end else begin
            state <= ST_EREQ;
          end
        end
        ST_EREQ: state <= ST_EWAIT;
        ST_EWAIT: begin
          if (edidDone) begin
            verdictQ <= edidOk ? RSN_NONE : RSN_EDID;
            state    <= ST_FINISH;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.clearBuf = (state == ST_REQ);
    strobes.collect  = (state == ST_WAIT);
    strobes.commit   = (state == ST_FINISH);
    strobes.verdict  = verdictQ;
  end

  assign burstReq = (state == ST_REQ);
  assign edidReq  = (state == ST_EREQ);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/sink_cap_dpath.sv
module sink_cap_dpath
  import sink_cap_pkg::*;
#(
  parameter int BURST_LEN = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobes,
  input  logic       rspValid,
  input  logic [7:0] rspData,
  output flags_t     flags,
  output logic       doneOut,
  output logic       passOut,
  output logic [2:0] reasonCode,
  output logic [7:0] capRev,
  output logic [7:0] capRate,
  output logic [4:0] capLanes,
  output logic       capEnhFrame
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BURST_LEN);

  logic [7:0] capBuf [BURST_LEN];
  logic [CNT_W-1:0] byteCnt;
  logic overrun;

  // byte counter with overrun detection
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearBuf) begin
      byteCnt <= '0;
      overrun <= 1'b0;
    end else if (strobes.collect && rspValid) begin
      if (byteCnt == FULL_CNT) overrun <= 1'b1;
      else                     byteCnt <= byteCnt + 1'b1;
    end
  end

  for (genvar i = 0; i < BURST_LEN; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearBuf) begin
        capBuf[i] <= '0;
      end else if (strobes.collect && rspValid && byteCnt == CNT_W'(i)) begin
        capBuf[i] <= rspData;
      end
    end
  end

  // field decode
  logic [7:0] revByte, rateByte, laneByte, laneVal;
  logic       isV11, enhCap;

  always_comb begin
    revByte  = capBuf[0];
    rateByte = capBuf[1];
    laneByte = capBuf[2];
    isV11    = (revByte == REV_V11);
    laneVal  = isV11 ? {3'b000, laneByte[4:0]} : laneByte;
    enhCap   = isV11 & laneByte[7];
    flags.countOk = (byteCnt == FULL_CNT) && !overrun;
    flags.revBad  = !((revByte == REV_V10) || isV11);
    flags.rateBad = !((rateByte == RATE_LOW) || (rateByte == RATE_HIGH));
    flags.laneBad = !((laneVal == 8'd1) || (laneVal == 8'd2) || (laneVal == 8'd4));
  end

  // result registers
  logic acceptNow;
  assign acceptNow = (strobes.verdict == RSN_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneOut     <= 1'b0;
      passOut     <= 1'b0;
      reasonCode  <= '0;
      capRev      <= '0;
      capRate     <= '0;
      capLanes    <= '0;
      capEnhFrame <= 1'b0;
    end else begin
      doneOut <= strobes.commit;
      if (strobes.commit) begin
        passOut    <= acceptNow;
        reasonCode <= strobes.verdict;
        if (acceptNow) begin
          capRev      <= revByte;
          capRate     <= rateByte;
          capLanes    <= laneVal[4:0];
          capEnhFrame <= enhCap;
        end else begin
          capRev      <= '0;
          capRate     <= '0;
          capLanes    <= '0;
          capEnhFrame <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sink_cap_reader.sv
module sink_cap_reader
  import sink_cap_pkg::*;
#(
  parameter int BURST_LEN = 12,
  parameter int MAX_TRIES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       edidPreloaded,
  output logic       burstReq,
  output logic [7:0] burstAddr,
  output logic [7:0] burstLen,
  input  logic       rspValid,
  input  logic [7:0] rspData,
  input  logic       rspDone,
  input  logic       rspFail,
  output logic       edidReq,
  input  logic       edidDone,
  input  logic       edidOk,
  output logic       busyOut,
  output logic       doneOut,
  output logic       passOut,
  output logic [2:0] reasonCode,
  output logic [7:0] capRev,
  output logic [7:0] capRate,
  output logic [4:0] capLanes,
  output logic       capEnhFrame
);

  strobe_t strobes;
  flags_t  flags;

  assign burstAddr = 8'h00;
  assign burstLen  = 8'(BURST_LEN);

  sink_cap_ctrl #(.MAX_TRIES(MAX_TRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .edidPreloaded(edidPreloaded),
    .rspDone(rspDone), .rspFail(rspFail), .edidDone(edidDone), .edidOk(edidOk),
    .flags(flags), .strobes(strobes), .burstReq(burstReq), .edidReq(edidReq),
    .busy(busyOut)
  );

  sink_cap_dpath #(.BURST_LEN(BURST_LEN)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rspValid(rspValid),
    .rspData(rspData), .flags(flags), .doneOut(doneOut), .passOut(passOut),
    .reasonCode(reasonCode), .capRev(capRev), .capRate(capRate),
    .capLanes(capLanes), .capEnhFrame(capEnhFrame)
  );

endmodule

// File: rtl/sink_cap_checker.sv
module sink_cap_checker (
  input logic       clk,
  input logic       rstN,
  input logic       burstReq,
  input logic       edidReq,
  input logic       busyOut,
  input logic       doneOut,
  input logic       passOut,
  input logic [2:0] reasonCode,
  input logic [7:0] capRev,
  input logic [7:0] capRate,
  input logic [4:0] capLanes,
  input logic       capEnhFrame
);

  // R2
  burst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstReq |=> !burstReq);

  // R9
  edid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    edidReq |=> !edidReq);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (!busyOut && !burstReq && !edidReq));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R11
  pass_reason_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && passOut) |-> (reasonCode == 3'd0));

  // R4
  pass_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && passOut) |-> (capRev == 8'h10 || capRev == 8'h11));

  // R5
  pass_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && passOut) |-> (capRate == 8'h06 || capRate == 8'h0A));

  // R7
  pass_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && passOut) |-> $onehot0(capLanes) && (capLanes != 5'd0) && (capLanes != 5'd8) && (capLanes != 5'd16));

  // R6
  v10_noenh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && capRev == 8'h10) |-> !capEnhFrame);

  // R11
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !passOut) |-> (capRev == 8'd0 && capRate == 8'd0 && capLanes == 5'd0 && !capEnhFrame));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && !doneOut && $past(!busyOut)) |-> ($stable(passOut) && $stable(reasonCode)));

endmodule

bind sink_cap_reader sink_cap_checker i_sink_cap_checker (
  .clk(clk), .rstN(rstN), .burstReq(burstReq), .edidReq(edidReq),
  .busyOut(busyOut), .doneOut(doneOut), .passOut(passOut),
  .reasonCode(reasonCode), .capRev(capRev), .capRate(capRate),
  .capLanes(capLanes), .capEnhFrame(capEnhFrame)
);

// File: tb/test_sink_cap_reader.sv
module test_sink_cap_reader;

  localparam int CLK_PERIOD = 10;
  localparam int TRIES = 5;
  localparam int BLEN = 12;
  localparam int WAIT_LIMIT = 200;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, edidPreloaded = 1'b0;
  logic rspValid = 1'b0, rspDone = 1'b0, rspFail = 1'b0;
  logic [7:0] rspData = 8'h00;
  logic edidDone = 1'b0, edidOk = 1'b0;
  logic burstReq, edidReq, busyOut, doneOut, passOut, capEnhFrame;
  logic [7:0] burstAddr, burstLen, capRev, capRate;
  logic [4:0] capLanes;
  logic [2:0] reasonCode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int reqSeen = 0;
  int edidSeen = 0;

  // results captured at done
  logic rPass, rEnh;
  logic [2:0] rReason;
  logic [7:0] rRev, rRate;
  logic [4:0] rLanes;
  int rBursts, rEdids;
  logic rAddrOk;

  always #(CLK_PERIOD/2) clk = ~clk;

  sink_cap_reader i_sink_cap_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .edidPreloaded(edidPreloaded),
    .burstReq(burstReq), .burstAddr(burstAddr), .burstLen(burstLen),
    .rspValid(rspValid), .rspData(rspData), .rspDone(rspDone), .rspFail(rspFail),
    .edidReq(edidReq), .edidDone(edidDone), .edidOk(edidOk),
    .busyOut(busyOut), .doneOut(doneOut), .passOut(passOut),
    .reasonCode(reasonCode), .capRev(capRev), .capRate(capRate),
    .capLanes(capLanes), .capEnhFrame(capEnhFrame)
  );

  always @(negedge clk) begin
    if (burstReq) reqSeen++;
    if (edidReq) edidSeen++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired: actual cycles=%0d expected < %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitSig(input string what, ref logic sig);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sig && n < WAIT_LIMIT);
    if (!sig) begin
      checks++;
      failures++;
      $display("FAIL timeout waiting for %s: actual=0 expected=1", what);
    end
  endtask

  function automatic logic [7:0] fillByte(input int k, input logic [7:0] b0,
                                          input logic [7:0] b1, input logic [7:0] b2);
    if (k == 0) return b0;
    if (k == 1) return b1;
    if (k == 2) return b2;
    return 8'hA0 + 8'(k);
  endfunction

  task automatic runOp(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input int failN, input bit shortFirst, input bit pre,
                       input bit expectEdid, input bit edidOkIn, input bit pokeStart);
    int reqBase, edidBase;
    reqBase = reqSeen;
    edidBase = edidSeen;
    rAddrOk = 1'b1;
    edidPreloaded = pre;
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    for (int a = 0; a < TRIES; a++) begin
      bit bad;
      int n;
      waitSig("burstReq", burstReq);
      if (burstAddr != 8'h00 || burstLen != 8'(BLEN)) rAddrOk = 1'b0;
      n = (shortFirst && a == 0) ? BLEN - 1 : BLEN;
      for (int k = 0; k < n; k++) begin
        @(posedge clk); #1;
        rspValid = 1'b1;
        rspData = fillByte(k, b0, b1, b2);
        startReq = (pokeStart && a == 0 && k == 3);
      end
      @(posedge clk); #1;
      startReq = 1'b0;
      rspValid = 1'b0;
      rspDone = 1'b1;
      bad = (a < failN) || (shortFirst && a == 0);
      rspFail = (a < failN);
      @(posedge clk); #1;
      rspDone = 1'b0;
      rspFail = 1'b0;
      if (!bad) break;
    end
    if (expectEdid) begin
      waitSig("edidReq", edidReq);
      @(posedge clk); #1 edidDone = 1'b1; edidOk = edidOkIn;
      @(posedge clk); #1 edidDone = 1'b0; edidOk = 1'b0;
    end
    waitSig("doneOut", doneOut);
    rPass = passOut; rReason = reasonCode; rRev = capRev; rRate = capRate;
    rLanes = capLanes; rEnh = capEnhFrame;
    chk("R10 busy low at done", int'(busyOut), 0);
    rBursts = reqSeen - reqBase;
    rEdids = edidSeen - edidBase;
  endtask

  task automatic expectPass(input string req, input logic [7:0] rev, input logic [7:0] rate,
                            input logic [4:0] lanes, input logic enh);
    chk({req, " pass"}, int'(rPass), 1);
    chk("R11 reason on pass", int'(rReason), 0);
    chk({req, " rev"}, int'(rRev), int'(rev));
    chk({req, " rate"}, int'(rRate), int'(rate));
    chk({req, " lanes"}, int'(rLanes), int'(lanes));
    chk({req, " enh"}, int'(rEnh), int'(enh));
  endtask

  task automatic expectFail(input string req, input int reason);
    chk({req, " pass"}, int'(rPass), 0);
    chk({req, " reason"}, int'(rReason), reason);
    chk("R11 fields zero on fail", int'({rRev, rRate, rLanes, rEnh}), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 busy", int'(busyOut), 0);
    chk("R1 done", int'(doneOut), 0);
    chk("R1 pass", int'(passOut), 0);
    chk("R1 reason", int'(reasonCode), 0);
    chk("R1 reqs", int'({burstReq, edidReq}), 0);
    chk("R1 fields", int'({capRev, capRate, capLanes, capEnhFrame}), 0);
  endtask

  task automatic testV11Edid();
    runOp(8'h11, 8'h0A, 8'h84, 0, 0, 0, 1, 1, 1);
    expectPass("R6 v11 lanes4 enh", 8'h11, 8'h0A, 5'd4, 1'b1);
    chk("R2 addr/len", int'(rAddrOk), 1);
    chk("R10 start while busy ignored bursts", rBursts, 1);
    chk("R9 edid requested once", rEdids, 1);
  endtask

  task automatic testV10Preloaded();
    runOp(8'h10, 8'h06, 8'h02, 0, 0, 1, 0, 0, 0);
    expectPass("R6 v10 lanes2", 8'h10, 8'h06, 5'd2, 1'b0);
    chk("R9 preloaded skips edid", rEdids, 0);
  endtask

  task automatic testV10HighBit();
    runOp(8'h10, 8'h06, 8'h81, 0, 0, 1, 0, 0, 0);
    expectFail("R6 v10 whole byte lane", 4);
  endtask

  task automatic testV11Masked();
    runOp(8'h11, 8'h06, 8'h22, 0, 0, 1, 0, 0, 0);
    expectPass("R6 v11 low five bits", 8'h11, 8'h06, 5'd2, 1'b0);
    runOp(8'h11, 8'h0A, 8'h81, 0, 0, 1, 0, 0, 0);
    expectPass("R6 v11 lanes1 enh", 8'h11, 8'h0A, 5'd1, 1'b1);
  endtask

  task automatic testLaneBad();
    runOp(8'h11, 8'h06, 8'h03, 0, 0, 1, 0, 0, 0);
    expectFail("R7 three lanes", 4);
    runOp(8'h10, 8'h0A, 8'h00, 0, 0, 1, 0, 0, 0);
    expectFail("R7 zero lanes", 4);
  endtask

  task automatic testRevBad();
    runOp(8'h12, 8'h06, 8'h01, 0, 0, 1, 0, 0, 0);
    expectFail("R4 rev 0x12", 2);
  endtask

  task automatic testRateBad();
    runOp(8'h10, 8'h14, 8'h01, 0, 0, 1, 0, 0, 0);
    expectFail("R5 rate 0x14", 3);
  endtask

  task automatic testOrder();
    runOp(8'h20, 8'h07, 8'h05, 0, 0, 1, 0, 0, 0);
    expectFail("R8 rev first", 2);
    runOp(8'h11, 8'h07, 8'h05, 0, 0, 1, 0, 0, 0);
    expectFail("R8 rate before lanes", 3);
  endtask

  task automatic testRetryLast();
    runOp(8'h10, 8'h0A, 8'h04, TRIES - 1, 0, 1, 0, 0, 0);
    expectPass("R3 pass on last try", 8'h10, 8'h0A, 5'd4, 1'b0);
    chk("R3 bursts used", rBursts, TRIES);
  endtask

  task automatic testRetryExhaust();
    runOp(8'h10, 8'h0A, 8'h04, TRIES, 0, 0, 0, 0, 0);
    expectFail("R3 retries exhausted", 1);
    chk("R3 bursts issued", rBursts, TRIES);
    chk("R3 no edid after read fail", rEdids, 0);
  endtask

  task automatic testShortBurst();
    runOp(8'h11, 8'h06, 8'h01, 0, 1, 1, 0, 0, 0);
    expectPass("R3 short burst retried", 8'h11, 8'h06, 5'd1, 1'b0);
    chk("R3 short burst count", rBursts, 2);
  endtask

  task automatic testEdidBad();
    runOp(8'h11, 8'h06, 8'h02, 0, 0, 0, 1, 0, 0);
    expectFail("R9 edid fetch failed", 5);
  endtask

  task automatic testHold();
    runOp(8'h11, 8'h0A, 8'h82, 0, 0, 1, 0, 0, 0);
    expectPass("R10 before hold", 8'h11, 8'h0A, 5'd2, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 done is a pulse", int'(doneOut), 0);
    chk("R10 pass held", int'(passOut), 1);
    chk("R10 lanes held", int'(capLanes), 2);
    chk("R10 enh held", int'(capEnhFrame), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(posedge clk); #1 rstN = 1'b1;
    testV11Edid();
    testV10Preloaded();
    testV10HighBit();
    testV11Masked();
    testLaneBad();
    testRevBad();
    testRateBad();
    testOrder();
    testRetryLast();
    testRetryExhaust();
    testShortBurst();
    testEdidBad();
    testHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule